// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer with Watchdog Reset

This peripheral holds three down-counters behind a small register bus. Each channel has a live count register and a reload register. Channels 0 and 1 serve as general-purpose event or time-base counters. The last channel acts as a watchdog: when it expires it can pull a reset request output, gated by a separate enable register. One control word holds every channel's run, auto-reload and tick-source bits. Expiries are collected in a cause register, which software acknowledges bit by bit. A mask register selects which causes reach the single interrupt line.

Each channel counts either on every clock or only on cycles where an external fixed-rate strobe `slow_tick` is high. This keeps the whole block in one clock domain. Software starts a channel by writing the count register to set the first interval, the reload register to set later periods, and then the control word. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle.

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `rst_req` are low.
- R2: A channel whose run bit is clear keeps its count value unchanged, whatever `slow_tick` does.
- R3: A running channel decrements by one on each tick. Its source bit (control bit 3n+2) picks the tick: 0 counts every clock, 1 counts only cycles with `slow_tick` high.
- R4: A write to a count register loads that value directly, whatever the reload value is, and takes precedence over counting in the same cycle.
- R5: One-shot mode (auto bit clear): a tick while the count is 0 is an expiry. The count stays 0 and the channel's run bit clears itself.
- R6: Periodic mode (auto bit set): an expiry tick loads the reload value, and the run bit stays set.
- R7: Expiry of channel n sets cause bit n. A cause write clears each bit written as 0 and leaves each bit written as 1. A set in the same cycle as a clear wins.
- R8: `irq` is high exactly when some cause bit and its matching mask bit (bit n of the mask register) are both set.
- R9: Channel 2 is the watchdog. `rst_req` is high while cause bit 2 is set and bit 0 of the reset-enable register is set.
- R10: Writing a channel's run and auto bits as 0 stops it at once. Later ticks neither change its count nor raise its cause bit.
- R11: Address map (byte addresses):
  - control at 0x00, with run at bit 3n, auto at bit 3n+1 and source at bit 3n+2;
  - count n at 0x10+8n, and reload n at 0x14+8n;
  - cause at 0x40, mask at 0x44, and reset-enable at 0x48;
  - unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Fixed-rate strobe, one clock wide, used by channels in slow-source mode |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of masked cause bits |
| rst_req | output | 1 | Watchdog reset request, gated by reset-enable |

## Verification
The properties assume that `slow_tick` and `bus_wr` are clean single-cycle levels sampled at the clock edge. They also assume that a write to a count register and that register's own expiry may meet in one cycle only in the ways the requirements order. The stimulus changes inputs only on the falling edge. It produces slow ticks as isolated one-cycle pulses, so every decrement can be counted. It holds the other channels stopped while one channel is under test, so a shared strobe never moves a counter the expected values do not track. The one deliberate collision, a cause clear in the same cycle as an expiry, is driven on purpose to check the set-wins rule.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the timer/watchdog block.
// Assumes byte addressing with 32-bit aligned registers.
package tmr_pkg;
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_CNT0  = 'h10;
    localparam int OFF_RLD0  = 'h14;
    localparam int STRIDE    = 8;
    localparam int OFF_CAUSE = 'h40;
    localparam int OFF_MASK  = 'h44;
    localparam int OFF_RSTEN = 'h48;

    localparam int CB_RUN  = 0;
    localparam int CB_AUTO = 1;
    localparam int CB_SRC  = 2;
    localparam int CB_W    = 3;

    // Per-channel slice of the control word; bit order matches CB_* above.
    typedef struct packed {
        logic src_slow;
        logic auto_rl;
        logic run;
    } chan_ctl_t;
endpackage

// File: rtl/tmr_chan.sv
// One down-counting channel: count and reload storage, tick selection,
// expiry detection. Assumes the run bit is held outside and cleared by
// the owner when stop_req pulses.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_ctl_t     ctl,
    input  logic          slow_tick,
    input  logic          cnt_we,
    input  logic          rld_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] rld_q,
    output logic          expire,
    output logic          stop_req
);
    logic tick;
    logic fire;
    logic at_zero;

    // Pick the count source and qualify with the run bit.
    always_comb begin
        tick     = ctl.src_slow ? slow_tick : 1'b1;
        fire     = ctl.run && tick;
        at_zero  = (cnt_q == '0);
        expire   = fire && at_zero && !cnt_we;
        stop_req = expire && !ctl.auto_rl;
    end

    // Reload register: plain software-written storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (rld_we) rld_q <= wdata;
    end

    // Counter: software write first, then reload on expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= wdata;
        end else if (fire) begin
            if (at_zero) begin
                if (ctl.auto_rl) cnt_q <= rld_q;
            end else begin
                cnt_q <= cnt_q - DW'(1);
            end
        end
    end
endmodule

// File: rtl/tmr_irq.sv
// Interrupt cause, interrupt mask and reset-enable registers. Assumes the
// watchdog is the highest-numbered channel. Expiry sets win over clears.
module tmr_irq #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] expire,
    input  logic           cause_we,
    input  logic           mask_we,
    input  logic           rsten_we,
    input  logic [NCH-1:0] wbits,
    input  logic           wbit0,
    output logic [NCH-1:0] cause_q,
    output logic [NCH-1:0] mask_q,
    output logic           rsten_q,
    output logic           irq,
    output logic           rst_req
);
    localparam int WD = NCH - 1;

    logic [NCH-1:0] cause_keep;

    // Written zeros clear; untouched bits are kept.
    always_comb cause_keep = cause_we ? (cause_q & wbits) : cause_q;

    // Cause register: new expiries are ORed in after the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_keep | expire;
    end

    // Mask and reset-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rsten_q <= 1'b0;
        end else begin
            if (mask_we)  mask_q  <= wbits;
            if (rsten_we) rsten_q <= wbit0;
        end
    end

    // Output gating for the interrupt and the watchdog reset request.
    always_comb begin
        irq     = |(cause_q & mask_q);
        rst_req = cause_q[WD] && rsten_q;
    end
endmodule

// File: rtl/tmr_wdog_top.sv
// Top of the timer/watchdog: register decode, shared control word,
// channel array and read multiplexer. Assumes single-cycle write strobes
// and combinational reads.
module tmr_wdog_top
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 32,
    parameter int AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          rst_req
);
    localparam int CTW = CB_W * NCH;

    logic [CTW-1:0]         ctrl_q;
    logic [NCH-1:0][DW-1:0] cnt_q;
    logic [NCH-1:0][DW-1:0] rld_q;
    logic [NCH-1:0]         expire;
    logic [NCH-1:0]         stop_req;
    logic [NCH-1:0]         cnt_we;
    logic [NCH-1:0]         rld_we;
    logic [NCH-1:0]         cause_q;
    logic [NCH-1:0]         mask_q;
    logic                   rsten_q;
    logic                   ctrl_we;
    logic                   cause_we;
    logic                   mask_we;
    logic                   rsten_we;
    int                     addr_i;

    // Address decode for the single-register writes.
    always_comb begin
        addr_i   = int'(bus_addr);
        ctrl_we  = bus_wr && (addr_i == OFF_CTRL);
        cause_we = bus_wr && (addr_i == OFF_CAUSE);
        mask_we  = bus_wr && (addr_i == OFF_MASK);
        rsten_we = bus_wr && (addr_i == OFF_RSTEN);
    end

    // Control word: software write wins, else one-shot expiries drop run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= bus_wdata[CTW-1:0];
        end else begin
            for (int n = 0; n < NCH; n++)
                if (stop_req[n]) ctrl_q[CB_W*n + CB_RUN] <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Per-channel write decode at the 8-byte stride.
        always_comb begin
            cnt_we[g] = bus_wr && (addr_i == OFF_CNT0 + g*STRIDE);
            rld_we[g] = bus_wr && (addr_i == OFF_RLD0 + g*STRIDE);
        end

        tmr_chan #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (chan_ctl_t'(ctrl_q[CB_W*g +: CB_W])),
            .slow_tick(slow_tick),
            .cnt_we   (cnt_we[g]),
            .rld_we   (rld_we[g]),
            .wdata    (bus_wdata),
            .cnt_q    (cnt_q[g]),
            .rld_q    (rld_q[g]),
            .expire   (expire[g]),
            .stop_req (stop_req[g])
        );
    end

    tmr_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .cause_we(cause_we),
        .mask_we (mask_we),
        .rsten_we(rsten_we),
        .wbits   (bus_wdata[NCH-1:0]),
        .wbit0   (bus_wdata[0]),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .rsten_q (rsten_q),
        .irq     (irq),
        .rst_req (rst_req)
    );

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (addr_i == OFF_CTRL)  bus_rdata[CTW-1:0] = ctrl_q;
        if (addr_i == OFF_CAUSE) bus_rdata[NCH-1:0] = cause_q;
        if (addr_i == OFF_MASK)  bus_rdata[NCH-1:0] = mask_q;
        if (addr_i == OFF_RSTEN) bus_rdata[0]       = rsten_q;
        for (int n = 0; n < NCH; n++) begin
            if (addr_i == OFF_CNT0 + n*STRIDE) bus_rdata = cnt_q[n];
            if (addr_i == OFF_RLD0 + n*STRIDE) bus_rdata = rld_q[n];
        end
    end
endmodule

// File: rtl/tmr_wdog_chk.sv
// Property checker for tmr_wdog_top, attached by bind. Assumes the
// control-word layout of tmr_pkg.
module tmr_wdog_chk
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   slow_tick,
    input logic [CB_W*NCH-1:0]    ctrl_q,
    input logic                   ctrl_we,
    input logic [NCH-1:0][DW-1:0] cnt_q,
    input logic [NCH-1:0]         cnt_we,
    input logic [NCH-1:0]         expire,
    input logic [NCH-1:0]         cause_q,
    input logic [NCH-1:0]         mask_q,
    input logic                   mask_we,
    input logic                   rsten_q,
    input logic                   rsten_we,
    input logic                   irq,
    input logic                   rst_req
);
    localparam int WD = NCH - 1;

    for (genvar g = 0; g < NCH; g++) begin : g_p
        logic run, aut, tk;
        always_comb begin
            run = ctrl_q[CB_W*g + CB_RUN];
            aut = ctrl_q[CB_W*g + CB_AUTO];
            tk  = ctrl_q[CB_W*g + CB_SRC] ? slow_tick : 1'b1;
        end

        p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !run && !cnt_we[g] |=> cnt_q[g] == $past(cnt_q[g]));

        p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
            run && tk && cnt_q[g] != '0 && !cnt_we[g]
            |=> cnt_q[g] == $past(cnt_q[g]) - DW'(1));

        p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            run && !aut && tk && cnt_q[g] == '0 && !cnt_we[g] && !ctrl_we
            |=> !ctrl_q[CB_W*g + CB_RUN] && cnt_q[g] == '0);

        p_cause_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> cause_q[g]);

        p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] && mask_q[g] && !mask_we |=> irq);
    end

    p_rst_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire[WD] && rsten_q && !rsten_we |=> rst_req);

    p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(expire[WD]) || $past(rsten_we));
endmodule

bind tmr_wdog_top tmr_wdog_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_tick(slow_tick),
    .ctrl_q   (ctrl_q),
    .ctrl_we  (ctrl_we),
    .cnt_q    (cnt_q),
    .cnt_we   (cnt_we),
    .expire   (expire),
    .cause_q  (cause_q),
    .mask_q   (mask_q),
    .mask_we  (mask_we),
    .rsten_q  (rsten_q),
    .rsten_we (rsten_we),
    .irq      (irq),
    .rst_req  (rst_req)
);

// File: tb/sim_tmr_wdog_top.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module sim_tmr_wdog_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;
    logic        rd_act = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    typedef struct {
        logic [31:0] exp;
        logic [7:0]  addr;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    tmr_wdog_top u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk); bus_addr = a; rd_act = 1'b1;
        it.exp = e; it.addr = a; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1 rd_act = 1'b0;
    endtask

    task automatic tick(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(posedge clk); #1 slow_tick = 1'b0;
        end
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        @(negedge clk); #1;
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0b expected %0b", tag, got, exp);
        end
    endtask

    // Monitor: pop and compare each read a little after the falling edge.
    always @(negedge clk) begin
        #1;
        if (rd_act && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_run++;
            if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr %h got %h expected %h",
                         it.tag, it.addr, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R11 unmapped read
        rd(8'h00, 32'h0, "R1 ctrl");
        rd(8'h10, 32'h0, "R1 cnt0");
        rd(8'h24, 32'h0, "R1 rld2");
        rd(8'h40, 32'h0, "R1 cause");
        rd(8'h48, 32'h0, "R1 rsten");
        chk(irq, 1'b0, "R1 irq");
        chk(rst_req, 1'b0, "R1 rst_req");
        rd(8'h3C, 32'h0, "R11 unmapped");
        // R2 stopped channel holds
        wr(8'h10, 32'd5);
        tick(2);
        rd(8'h10, 32'd5, "R2 hold");
        // R4 and R6 periodic with first interval apart from reload
        wr(8'h14, 32'd3);
        wr(8'h10, 32'd1);
        wr(8'h00, 32'h7);
        tick(1);
        rd(8'h10, 32'd0, "R3 slow step");
        tick(1);
        rd(8'h10, 32'd3, "R6 reload");
        rd(8'h00, 32'h7, "R6 run kept");
        rd(8'h40, 32'h1, "R7 cause set");
        chk(irq, 1'b0, "R8 masked");
        wr(8'h44, 32'h1);
        chk(irq, 1'b1, "R8 unmasked");
        wr(8'h40, 32'hFFFF_FFFE);
        rd(8'h40, 32'h0, "R7 clear");
        chk(irq, 1'b0, "R8 after clear");
        tick(3);
        rd(8'h10, 32'd0, "R6 count to zero");
        tick(1);
        rd(8'h10, 32'd3, "R6 second reload");
        rd(8'h40, 32'h1, "R7 second set");
        // R7 set wins over clear in the same cycle
        wr(8'h40, 32'hFFFF_FFFE);
        tick(3);
        @(negedge clk);
        bus_addr = 8'h40; bus_wdata = 32'hFFFF_FFFE; bus_wr = 1'b1; slow_tick = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0; slow_tick = 1'b0;
        rd(8'h40, 32'h1, "R7 set wins");
        rd(8'h10, 32'd3, "R6 reload at collision");
        // R10 stop
        wr(8'h40, 32'hFFFF_FFFE);
        wr(8'h00, 32'h0);
        tick(5);
        rd(8'h10, 32'd3, "R10 count frozen");
        rd(8'h40, 32'h0, "R10 no cause");
        chk(irq, 1'b0, "R10 irq low");
        // R5 one-shot
        wr(8'h10, 32'd2);
        wr(8'h00, 32'h5);
        tick(2);
        rd(8'h00, 32'h5, "R5 running");
        tick(1);
        rd(8'h00, 32'h4, "R5 run cleared");
        rd(8'h10, 32'd0, "R5 held zero");
        rd(8'h40, 32'h1, "R5 cause");
        tick(1);
        rd(8'h10, 32'd0, "R5 stays zero");
        wr(8'h40, 32'hFFFF_FFFE);
        // R4 write wins and R3 core-clock source on channel 1
        wr(8'h18, 32'd100);
        wr(8'h00, 32'h8);
        rd(8'h18, 32'd100, "R4 loaded");
        repeat (9) @(posedge clk);
        rd(8'h18, 32'd90, "R3 core clock");
        wr(8'h00, 32'h0);
        // R9 watchdog channel
        wr(8'h20, 32'd1);
        wr(8'h00, 32'h140);
        tick(2);
        rd(8'h40, 32'h4, "R9 wd cause");
        rd(8'h00, 32'h100, "R9 wd one-shot");
        chk(rst_req, 1'b0, "R9 reset gated");
        wr(8'h48, 32'h1);
        chk(rst_req, 1'b1, "R9 reset out");
        chk(irq, 1'b0, "R8 wd masked");
        wr(8'h44, 32'h4);
        chk(irq, 1'b1, "R8 wd irq");
        wr(8'h40, 32'hFFFF_FFFB);
        chk(rst_req, 1'b0, "R9 reset cleared");
        chk(irq, 1'b0, "R8 wd cleared");
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule